// File: doc/BRIEF.md
# Sampled Edge Glitch Filter with Interrupt Flag

This block conditions one asynchronous input pin for use as an interrupt source. The pin first goes through a synchronizer. A qualification counter then looks at one sample per clock. An edge is accepted only when the pin has been seen at its inactive level for a full run of samples and then at its active level for a full run. With the default parameters both runs are four samples long. A polarity input sets which level counts as active, so the same filter detects either rising or falling edges.

An accepted edge sets a sticky flag. The flag is cleared by a write-one strobe and masked by an enable to form the interrupt request. The block also drives an oscillator request output. A low-power sampling clock source can use it to run only while the filter is waiting for, or building, an inactive run, and only while an interrupt could still be raised.

Top module: `pin_edge_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the flag and the interrupt request are 0. The oscillator request then equals the interrupt enable. All state resets asynchronously.
- R2: After at least 4 consecutive inactive samples, the flag rises on the 6th rising clock edge counted from the first edge at which an active pin level is present. This is 2 synchronizer stages plus 4 active samples. The filter's stage count is above 4 on the edges before that, while the active run is building.
- R3: When the polarity input is 1, the active level is 1 and rising edges qualify. When it is 0, the active level is 0 and falling edges qualify. An edge of the other direction never sets the flag.
- R4: An active pulse shorter than 4 samples never sets the flag. Once 4 inactive samples have armed the filter, a later inactive sample restarts the active run but keeps the filter armed. After such an interruption, 4 further active samples still qualify an edge.
- R5: After an edge qualifies, the filter needs 4 new inactive samples before it can qualify another edge. If the pin returns to inactive for fewer samples, no second edge is accepted.
- R6: If an active sample arrives before 4 inactive samples have been collected, the inactive count restarts from zero and no edge is qualified.
- R7: A 1 on the clear strobe clears the flag at the next clock edge. If an edge qualifies in the same cycle as the clear, the flag is set instead.
- R8: The interrupt request equals the flag ANDed with the interrupt enable. Driving the enable to 0 masks the request but leaves the flag set.
- R9: The oscillator request is 1 only when the filter's stage count is at most 4, the enable is 1 and the flag is 0. The stage count is 0 to 4 while inactive samples are being collected. It is 5 to 8 during an armed active run and stays at 8 after a qualified edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one pin sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous input pin |
| pol_i | input | 1 | Active level: 1 = rising edges, 0 = falling edges |
| ie_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| flag_o | output | 1 | Sticky qualified-edge flag |
| irq_o | output | 1 | Interrupt request (flag masked by enable) |
| osc_req_o | output | 1 | Request for the sampling clock source |

## Verification
The hardest case to reach from the ports is a clear strobe that lands exactly on the clock edge where a new edge qualifies, while the flag is already set. That cycle is the only one in which the set-over-clear priority can be seen. The stimulus keeps the flag set, re-arms the filter with a long inactive run, and raises the pin. It then counts five sample cycles through the synchronizer and counter and pulses the clear exactly on the sixth. A second hard case is the interrupted active run, which must stay armed. It is reached by placing a single inactive sample between two active runs, and a long random phase with varied run lengths is then compared against a behavioural model on every cycle.

// File: rtl/pef_pkg.sv
package pef_pkg;

   typedef enum logic {
      POL_FALL = 1'b0,
      POL_RISE = 1'b1
   } pef_pol_e;

   function automatic int pef_cnt_w(input int run_len);
      return $clog2(2 * run_len + 1);
   endfunction

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pef_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pef_qual.sv
module pef_qual
   import pef_pkg::*;
#(
   parameter int RUN_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_i,
   input  logic pol_i,
   output logic hit_o,
   output logic low_cnt_o
);

   localparam int CW   = pef_cnt_w(RUN_LEN);
   localparam int FULL = 2 * RUN_LEN;
   localparam logic [CW-1:0] C_RUN  = CW'(RUN_LEN);
   localparam logic [CW-1:0] C_FULL = CW'(FULL);
   localparam logic [CW-1:0] C_LAST = CW'(FULL - 1);
   localparam logic [CW-1:0] C_ONE  = CW'(1);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("pef_qual: RUN_LEN must be at least 1");
   end

   pef_pol_e        pol;
   logic            act;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   cnt_d;
   logic            hit;

   assign pol = pef_pol_e'(pol_i);
   assign act = (pol == POL_RISE) ? samp_i : ~samp_i;

   always_comb begin
      cnt_d = cnt_q;
      hit   = 1'b0;
      if (!act) begin
         if (cnt_q < C_RUN)       cnt_d = cnt_q + C_ONE;
         else if (cnt_q < C_FULL) cnt_d = C_RUN;
         else                     cnt_d = C_ONE;
      end else begin
         if (cnt_q < C_RUN) begin
            cnt_d = '0;
         end else if (cnt_q < C_FULL) begin
            cnt_d = cnt_q + C_ONE;
            hit   = (cnt_q == C_LAST);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign hit_o     = hit;
   assign low_cnt_o = (cnt_q <= C_RUN);

   if (RUN_LEN == 4) begin : g_run4_chk
      AST_EDGE_ACTIVE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
         hit_o |-> (act && $past(act) && $past(act, 2) && $past(act, 3))); // R4
   end

   AST_REARM_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o); // R5

endmodule

// File: rtl/pef_flag.sv
module pef_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clr_i,
   input  logic ie_i,
   input  logic low_cnt_i,
   output logic flag_o,
   output logic irq_o,
   output logic osc_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hit_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & ie_i;
   assign osc_o  = low_cnt_i & ie_i & ~flag_q;

   AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(flag_q) && flag_q) |-> $past(hit_i)); // R2

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q); // R8

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit_i) |=> !flag_q); // R7

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && hit_i) |=> flag_q); // R7

endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LEN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic pol_i,
   input  logic ie_i,
   input  logic clr_i,
   output logic flag_o,
   output logic irq_o,
   output logic osc_req_o
);

   logic samp;
   logic hit;
   logic low_cnt;

   pef_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (samp)
   );

   pef_qual #(.RUN_LEN(RUN_LEN)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_i    (samp),
      .pol_i     (pol_i),
      .hit_o     (hit),
      .low_cnt_o (low_cnt)
   );

   pef_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_i     (hit),
      .clr_i     (clr_i),
      .ie_i      (ie_i),
      .low_cnt_i (low_cnt),
      .flag_o    (flag_o),
      .irq_o     (irq_o),
      .osc_o     (osc_req_o)
   );

   AST_OSC_QUIET_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o |-> !osc_req_o); // R9

   AST_OSC_OFF_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !osc_req_o); // R9

endmodule

// File: tb/pin_edge_filter_tb.sv
`timescale 1ns/1ps
module pin_edge_filter_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin = 1'b0;
   logic pol = 1'b1;
   logic ie = 1'b1;
   logic clr = 1'b0;
   logic flag, irq, osc;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pin_edge_filter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin),
      .pol_i     (pol),
      .ie_i      (ie),
      .clr_i     (clr),
      .flag_o    (flag),
      .irq_o     (irq),
      .osc_req_o (osc)
   );

   // behavioural reference: sample pipeline queue and a qualification stage
   int m_pipe[$];
   int m_stage;
   int m_flag;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pipe = '{0, 0};
         m_stage = 0;
         m_flag = 0;
      end else begin
         int s;
         bit active, qualified;
         s = m_pipe.pop_front();
         m_pipe.push_back(int'(pin));
         active = ((s != 0) == pol);
         qualified = 0;
         if (!active) begin
            if (m_stage < 4) m_stage = m_stage + 1;
            else if (m_stage < 8) m_stage = 4;
            else m_stage = 1;
         end else begin
            if (m_stage < 4) m_stage = 0;
            else if (m_stage < 8) begin
               m_stage = m_stage + 1;
               qualified = (m_stage == 8);
            end
         end
         if (qualified) m_flag = 1;
         else if (clr) m_flag = 0;
      end
   end

   task automatic chk(input string tag, input logic actual, input logic expected);
      vectors++;
      if (actual !== expected) begin
         miscompares++;
         $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, actual, expected, cyc);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (rst_n) begin
         chk("R2/R7 flag vs model", flag, logic'(m_flag != 0));
         chk("R8 irq vs model", irq, logic'((m_flag != 0) && ie));
         chk("R9 osc_req vs model", osc, logic'((m_stage <= 4) && ie && (m_flag == 0)));
      end
   endtask

   task automatic hold(input int n);
      repeat (n) step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      pol = 1'b1; ie = 1'b1; clr = 1'b0; pin = 1'b0;
      hold(3);
      chk("R1 flag in reset", flag, 1'b0);
      chk("R1 irq in reset", irq, 1'b0);
      rst_n = 1'b1;
      step();
      chk("R1 flag after reset", flag, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 osc_req equals enable", osc, 1'b1);

      // short active pulse
      pin = 1'b0; hold(6);
      pin = 1'b1; hold(3);
      pin = 1'b0; hold(10);
      chk("R4 short pulse ignored", flag, 1'b0);

      // interrupted active run while armed
      pin = 1'b1; hold(2);
      pin = 1'b0; hold(1);
      pin = 1'b1; hold(8);
      chk("R4 indirect qualification", flag, 1'b1);

      clr = 1'b1; hold(1); clr = 1'b0;
      chk("R7 clear strobe", flag, 1'b0);

      // too few new inactive samples after an edge
      pin = 1'b0; hold(2);
      pin = 1'b1; hold(8);
      chk("R5 no re-arm after 2 inactive", flag, 1'b0);
      pin = 1'b0; hold(3);
      pin = 1'b1; hold(8);
      chk("R6 three inactive samples insufficient", flag, 1'b0);

      // exact latency
      pin = 1'b0; hold(8);
      pin = 1'b1; hold(5);
      chk("R2 flag not yet set", flag, 1'b0);
      chk("R9 osc_req low during active run", osc, 1'b0);
      hold(1);
      chk("R2 flag set on 6th edge", flag, 1'b1);
      chk("R2 irq follows", irq, 1'b1);

      // set wins over clear in the same cycle
      pin = 1'b0; hold(8);
      pin = 1'b1; hold(5);
      clr = 1'b1; hold(1); clr = 1'b0;
      chk("R7 set beats clear", flag, 1'b1);

      ie = 1'b0; hold(1);
      chk("R8 irq masked", irq, 1'b0);
      chk("R8 flag kept while masked", flag, 1'b1);
      chk("R9 osc_req off without enable", osc, 1'b0);
      ie = 1'b1; hold(1);
      chk("R8 irq restored", irq, 1'b1);

      clr = 1'b1; hold(1); clr = 1'b0;
      chk("R9 osc_req low after qualified edge", osc, 1'b0);
      pin = 1'b0; hold(3);
      chk("R9 osc_req high while collecting inactive", osc, 1'b1);

      // falling-edge polarity
      pol = 1'b0;
      pin = 1'b1; hold(8);
      pin = 1'b0; hold(8);
      chk("R3 falling edge qualifies", flag, 1'b1);
      clr = 1'b1; hold(1); clr = 1'b0;
      pin = 1'b1; hold(10);
      chk("R3 rising edge ignored when falling selected", flag, 1'b0);

      // random phase compared against the model each cycle
      for (int k = 0; k < 600; k++) begin
         pin = ~pin;
         if ($urandom_range(0, 15) == 0) pol = ~pol;
         ie  = ($urandom_range(0, 7) != 0);
         clr = ($urandom_range(0, 5) == 0);
         hold($urandom_range(1, 7));
         clr = 1'b0;
      end

      // asynchronous reset mid-run
      pin = 1'b0; hold(8);
      pin = ~pol; hold(4);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 async reset clears flag", flag, 1'b0);
      hold(2);
      rst_n = 1'b1;
      hold(4);

      finish_run();
   end

endmodule